// File: doc/BRIEF.md
# Credit-Gated Memory Access Point

This block sits at the edge of a core group's request mesh and serves exactly one DRAM module. It takes 256-bit request messages from the mesh. It confirms that each request's cache line maps to its module and drops any request that does not. It cuts each accepted message into four 64-bit flits. Each flit is spread across sixteen 4-bit lanes, one lane per optical wavelength, and sent toward the module's remote switch. Transmission is gated by a credit counter that mirrors the free flit slots in the switch buffer. The switch never signals back-pressure directly. Instead, it returns freed slots as a count carried in the head flit of each response message.

In the reverse direction, response flits arrive on the same kind of lane bundle. They are put back into bit order and collected into one 256-bit message, which is offered to the mesh. The mesh-facing request and response sides are valid/ready streams: a transfer happens on a clock edge where both valid and ready are high. Once valid is raised, the sender keeps it and the payload steady until that edge. The receive lane side also has a ready signal. It drops while a complete response is still waiting for the mesh.

Top module: `mem_access_point`

## Requirements
- R1: `req_ready` is high when no message is being sent, or when the last flit of the current message leaves in that cycle. It is low while a message is still in flight or stalled.
- R2: The destination index of a request is address bits [9:6] (the cache-line address modulo 16). A request whose index differs from `cfg_module_id` is still accepted, but it is dropped and sends no flit. `dest_err` is high for exactly the one cycle after the accepting edge.
- R3: Flit i of a message is `msg[64*i+63:64*i]`, and flit 0 holds the address. The flits leave in order 0..3, on consecutive cycles while credits allow. `tx_head` marks flit 0 and `tx_tail` marks flit 3. The flits of two messages are never interleaved.
- R4: Lane striping: lane L occupies `tx_lanes[4L+3:4L]`, and bit k of that nibble carries flit bit 16k+L.
- R5: The credit count resets to the `CREDITS` parameter (8 by default). It drops by one for each flit sent. No flit is sent while the count is zero.
- R6: Bits [63:56] of a response head flit are a credit return. They are added in the same edge that the head is accepted, and the sum saturates at `CREDITS`.
- R7: Response flits use the same lane mapping as R4. They are collected from head to tail, and the whole message is presented on `resp_msg` with `resp_valid` in the cycle after the tail is accepted. The message stays valid and unchanged until `resp_ready` is high.
- R8: `rx_ready` is low while a completed response waits for `resp_ready`.
- R9: After reset: `req_ready`=1, `rx_ready`=1, and `tx_valid`, `resp_valid` and `dest_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_module_id | input | 4 | Index of the DRAM module this point serves |
| req_valid | input | 1 | Request message offered by the mesh |
| req_ready | output | 1 | Request accepted this cycle |
| req_msg | input | 256 | Request message, address in bits [63:0] |
| dest_err | output | 1 | One-cycle pulse after a misrouted request is dropped |
| tx_valid | output | 1 | A flit is on the transmit lanes |
| tx_head | output | 1 | Transmit flit is flit 0 |
| tx_tail | output | 1 | Transmit flit is flit 3 |
| tx_lanes | output | 64 | 16 lanes x 4 bits, striped flit |
| rx_valid | input | 1 | Response flit present on receive lanes |
| rx_ready | output | 1 | Response flit accepted this cycle |
| rx_head | input | 1 | Receive flit is a head flit |
| rx_tail | input | 1 | Receive flit is a tail flit |
| rx_lanes | input | 64 | 16 lanes x 4 bits, striped response flit |
| resp_valid | output | 1 | Reassembled response available |
| resp_ready | input | 1 | Mesh takes the response |
| resp_msg | output | 256 | Reassembled response message |

## Verification
The bench drains the credits to zero partway through a message. A block that ignored the count would run past eight flits. A block that got the restart wrong would lose or repeat the stalled head. It returns a credit count far above the buffer depth to test saturation: a counter that wraps or does not clamp would release ten or more flits instead of eight. Addresses with nonzero line offsets and set upper bits probe the index slice, where an off-by-one field would drop good requests or pass bad ones. It also holds a finished response against a stalled mesh, where a design that let new flits in would corrupt the held message.

// File: rtl/map_pkg.sv
package map_pkg;
  localparam int FLIT_W     = 64;
  localparam int LANES      = 16;
  localparam int MSG_FLITS  = 4;
  localparam int MSG_W      = FLIT_W * MSG_FLITS;
  localparam int LINE_OFF   = 6;
  localparam int MOD_BITS   = 4;
  localparam int RET_W      = 8;
  localparam int CREDITS    = 8;
endpackage

// File: rtl/map_lane_swizzle.sv
module map_lane_swizzle #(
  parameter int  FLIT_W = 64,
  parameter int  LANES  = 16,
  parameter bit  UNPACK = 1'b0
) (
  input  logic [FLIT_W-1:0] din,
  output logic [FLIT_W-1:0] dout
);
  localparam int NIB = FLIT_W / LANES;

  // lane L, nibble bit k  <->  flit bit k*LANES + L
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar k = 0; k < NIB; k++) begin : g_bit
      if (UNPACK) begin : g_un
        assign dout[k*LANES + l] = din[l*NIB + k];
      end else begin : g_pk
        assign dout[l*NIB + k] = din[k*LANES + l];
      end
    end
  end
endmodule

// File: rtl/map_credit_ctr.sv
module map_credit_ctr #(
  parameter int MAX   = 8,
  parameter int RET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             ret_valid,
  input  logic [RET_W-1:0] ret_amt,
  output logic             have_credit
);
  localparam int CW = $clog2(MAX + 1);
  localparam int SW = ((CW > RET_W) ? CW : RET_W) + 2;

  logic [CW-1:0] cnt;
  logic [SW-1:0] nxt;

  always_comb begin
    nxt = SW'(cnt);
    if (ret_valid) nxt = nxt + SW'(ret_amt);
    if (take)      nxt = nxt - SW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= CW'(MAX);
    else if (nxt > SW'(MAX))   cnt <= CW'(MAX);
    else                       cnt <= nxt[CW-1:0];
  end

  assign have_credit = (cnt != '0);

  // R5
  credit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> cnt != '0);
  // R6
  credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX));
  // R6
  credit_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !take && cnt == CW'(MAX)) |=> cnt == CW'(MAX));
endmodule

// File: rtl/map_tx_frag.sv
module map_tx_frag #(
  parameter int FLIT_W    = 64,
  parameter int MSG_FLITS = 4,
  parameter int LINE_OFF  = 6,
  parameter int MOD_BITS  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [MOD_BITS-1:0]         my_id,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [FLIT_W*MSG_FLITS-1:0] req_msg,
  output logic                        err_mis,
  input  logic                        credit_ok,
  output logic                        flit_valid,
  output logic                        flit_head,
  output logic                        flit_tail,
  output logic [FLIT_W-1:0]           flit_data
);
  localparam int MSG_W = FLIT_W * MSG_FLITS;
  localparam int IW    = (MSG_FLITS > 1) ? $clog2(MSG_FLITS) : 1;

  logic             busy;
  logic [IW-1:0]    idx;
  logic [MSG_W-1:0] msg_q;
  logic             last, done, acc, hit;

  assign last       = (idx == IW'(MSG_FLITS - 1));
  assign flit_valid = busy && credit_ok;
  assign done       = flit_valid && last;
  assign req_ready  = !busy || done;
  assign acc        = req_valid && req_ready;
  assign hit        = (req_msg[LINE_OFF +: MOD_BITS] == my_id);

  assign flit_data  = msg_q[FLIT_W-1:0];
  assign flit_head  = (idx == '0);
  assign flit_tail  = last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      msg_q   <= '0;
      err_mis <= 1'b0;
    end else begin
      err_mis <= acc && !hit;
      if (flit_valid) begin
        msg_q <= msg_q >> FLIT_W;
        idx   <= idx + 1'b1;
        if (last) busy <= 1'b0;
      end
      if (acc && hit) begin
        msg_q <= req_msg;
        idx   <= '0;
        busy  <= 1'b1;
      end
    end
  end

  // R2
  dest_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_mis |-> $past(req_valid && req_ready));
  // R3
  no_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && !flit_tail) |=> !(flit_valid && flit_head));
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !flit_valid) |=> $stable(flit_data));
  // R1
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && !flit_tail) |-> !req_ready);
endmodule

// File: rtl/map_rx_asm.sv
module map_rx_asm #(
  parameter int FLIT_W    = 64,
  parameter int MSG_FLITS = 4,
  parameter int RET_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_valid,
  output logic                        rx_ready,
  input  logic                        rx_head,
  input  logic                        rx_tail,
  input  logic [FLIT_W-1:0]           rx_flit,
  output logic                        ret_valid,
  output logic [RET_W-1:0]            ret_amt,
  output logic                        resp_valid,
  input  logic                        resp_ready,
  output logic [FLIT_W*MSG_FLITS-1:0] resp_msg
);
  localparam int MSG_W = FLIT_W * MSG_FLITS;
  localparam int IW    = (MSG_FLITS > 1) ? $clog2(MSG_FLITS) : 1;

  logic             full;
  logic [IW-1:0]    idx, slot;
  logic [MSG_W-1:0] buf_q;
  logic             acc;

  assign rx_ready   = !full;
  assign acc        = rx_valid && rx_ready;
  assign slot       = rx_head ? '0 : idx;
  assign ret_valid  = acc && rx_head;
  assign ret_amt    = rx_flit[FLIT_W-1 -: RET_W];
  assign resp_valid = full;
  assign resp_msg   = buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full  <= 1'b0;
      idx   <= '0;
      buf_q <= '0;
    end else begin
      if (full && resp_ready) full <= 1'b0;
      if (acc) begin
        for (int s = 0; s < MSG_FLITS; s++)
          if (slot == IW'(s)) buf_q[s*FLIT_W +: FLIT_W] <= rx_flit;
        idx <= slot + 1'b1;
        if (rx_tail) full <= 1'b1;
      end
    end
  end

  // R7
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_msg)));
  // R8
  rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> !rx_ready);
endmodule

// File: rtl/mem_access_point.sv
module mem_access_point
  import map_pkg::*;
#(
  parameter int N_CREDITS = CREDITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MOD_BITS-1:0] cfg_module_id,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [MSG_W-1:0]    req_msg,
  output logic                dest_err,
  output logic                tx_valid,
  output logic                tx_head,
  output logic                tx_tail,
  output logic [FLIT_W-1:0]   tx_lanes,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic                rx_head,
  input  logic                rx_tail,
  input  logic [FLIT_W-1:0]   rx_lanes,
  output logic                resp_valid,
  input  logic                resp_ready,
  output logic [MSG_W-1:0]    resp_msg
);
  logic              credit_ok;
  logic [FLIT_W-1:0] tx_flit, rx_flit;
  logic              ret_valid;
  logic [RET_W-1:0]  ret_amt;

  map_tx_frag #(.FLIT_W(FLIT_W), .MSG_FLITS(MSG_FLITS),
                .LINE_OFF(LINE_OFF), .MOD_BITS(MOD_BITS)) u_frag (
    .clk(clk), .rst_n(rst_n), .my_id(cfg_module_id),
    .req_valid(req_valid), .req_ready(req_ready), .req_msg(req_msg),
    .err_mis(dest_err), .credit_ok(credit_ok),
    .flit_valid(tx_valid), .flit_head(tx_head), .flit_tail(tx_tail),
    .flit_data(tx_flit));

  map_lane_swizzle #(.FLIT_W(FLIT_W), .LANES(LANES), .UNPACK(1'b0)) u_tx_sw (
    .din(tx_flit), .dout(tx_lanes));

  map_credit_ctr #(.MAX(N_CREDITS), .RET_W(RET_W)) u_cred (
    .clk(clk), .rst_n(rst_n), .take(tx_valid),
    .ret_valid(ret_valid), .ret_amt(ret_amt), .have_credit(credit_ok));

  map_lane_swizzle #(.FLIT_W(FLIT_W), .LANES(LANES), .UNPACK(1'b1)) u_rx_sw (
    .din(rx_lanes), .dout(rx_flit));

  map_rx_asm #(.FLIT_W(FLIT_W), .MSG_FLITS(MSG_FLITS), .RET_W(RET_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_head(rx_head), .rx_tail(rx_tail), .rx_flit(rx_flit),
    .ret_valid(ret_valid), .ret_amt(ret_amt),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_msg(resp_msg));
endmodule

// File: tb/test_mem_access_point.sv
`timescale 1ns/1ps
module test_mem_access_point;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   cfg_module_id = 4'h5;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [255:0] req_msg = '0;
  logic         dest_err, tx_valid, tx_head, tx_tail;
  logic [63:0]  tx_lanes;
  logic         rx_valid = 1'b0, rx_head = 1'b0, rx_tail = 1'b0;
  logic         rx_ready;
  logic [63:0]  rx_lanes = '0;
  logic         resp_valid;
  logic         resp_ready = 1'b1;
  logic [255:0] resp_msg;

  mem_access_point i_mem_access_point (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] stripe(input logic [63:0] f);
    logic [63:0] l;
    for (int ln = 0; ln < 16; ln++)
      for (int k = 0; k < 4; k++) l[ln*4+k] = f[k*16+ln];
    return l;
  endfunction

  function automatic logic [63:0] destripe(input logic [63:0] l);
    logic [63:0] f;
    for (int ln = 0; ln < 16; ln++)
      for (int k = 0; k < 4; k++) f[k*16+ln] = l[ln*4+k];
    return f;
  endfunction

  function automatic logic [255:0] mk_req(input logic [63:0] a);
    return {a + 64'd1, ~a, a ^ 64'hA5A5_A5A5_A5A5_A5A5, a};
  endfunction

  function automatic logic [255:0] mk_resp(input logic [7:0] cr, input logic [63:0] s);
    return {s ^ 64'h0F0F_0F0F_0F0F_0F0F, ~s, s + 64'd7, {cr, s[55:0]}};
  endfunction

  // transmit monitor
  logic [63:0] cap_flit [64];
  bit          cap_head [64];
  bit          cap_tail [64];
  int          cap_cyc  [64];
  int          cap_n = 0;
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      cap_flit[cap_n % 64] = destripe(tx_lanes);
      cap_head[cap_n % 64] = tx_head;
      cap_tail[cap_n % 64] = tx_tail;
      cap_cyc[cap_n % 64]  = cyc;
      cap_n++;
    end
  end

  task automatic send_req(input logic [255:0] m, output bit e1, output bit e2);
    @(negedge clk); req_msg = m; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0; e1 = dest_err;
    @(negedge clk); e2 = dest_err;
  endtask

  task automatic send_resp(input logic [255:0] m);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_head = (i == 0); rx_tail = (i == 3);
      rx_lanes = stripe(m[64*i +: 64]);
      while (!rx_ready) @(negedge clk);
    end
    @(negedge clk); rx_valid = 1'b0; rx_head = 1'b0; rx_tail = 1'b0;
  endtask

  task automatic chk_msg_flits(input int base, input logic [255:0] m, input string tag);
    for (int i = 0; i < 4; i++) begin
      chk(cap_flit[(base+i)%64] == m[64*i +: 64], {tag, " R3 R4 flit data"},
          256'(cap_flit[(base+i)%64]), 256'(m[64*i +: 64]));
      chk(cap_head[(base+i)%64] == (i == 0) && cap_tail[(base+i)%64] == (i == 3),
          {tag, " R3 head/tail"}, 256'({cap_head[(base+i)%64], cap_tail[(base+i)%64]}),
          256'({i == 0, i == 3}));
    end
  endtask

  // vector table: {expect_match, address}; module id is 5 (address bits [9:6])
  localparam logic [64:0] VEC [8] = '{
    {1'b1, 64'h0000_0000_0000_0140},
    {1'b1, 64'hDEAD_BEEF_0000_0540},
    {1'b0, 64'h0000_0000_0000_0180},
    {1'b0, 64'hFFFF_FFFF_FFFF_FF7F},
    {1'b1, 64'h1234_5678_9ABC_D17F},
    {1'b0, 64'h0000_0000_0000_0000},
    {1'b1, 64'h8000_0000_0000_3D40},
    {1'b1, 64'h0000_0000_0000_0147}
  };

  task automatic run_all();
    bit e1, e2;
    int base;
    logic [255:0] m [3];
    logic [255:0] rm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(req_ready && rx_ready, "R9 readies", 256'({req_ready, rx_ready}), 256'(2'b11));
    chk(!tx_valid && !resp_valid && !dest_err, "R9 idle outputs",
        256'({tx_valid, resp_valid, dest_err}), 256'(0));

    // table walk
    for (int v = 0; v < 8; v++) begin
      rm = mk_resp(8'd4, VEC[v][63:0]);
      send_resp(rm);
      chk(resp_valid && resp_msg == rm, "R7 reassembled response", resp_msg, rm);
      base = cap_n;
      send_req(mk_req(VEC[v][63:0]), e1, e2);
      repeat (6) @(negedge clk);
      if (VEC[v][64]) begin
        chk(cap_n - base == 4, "R3 flit count", 256'(cap_n - base), 256'(4));
        chk_msg_flits(base, mk_req(VEC[v][63:0]), "vec");
        chk(cap_cyc[(base+3)%64] - cap_cyc[base%64] == 3, "R3 back-to-back",
            256'(cap_cyc[(base+3)%64] - cap_cyc[base%64]), 256'(3));
        chk(!e1, "R2 no error on hit", 256'(e1), 256'(0));
      end else begin
        chk(cap_n == base, "R2 dropped request sends nothing", 256'(cap_n - base), 256'(0));
        chk(e1 && !e2, "R2 one-cycle dest_err", 256'({e1, e2}), 256'(2'b10));
      end
    end

    // credit exhaustion mid-message (R5), credit return restart (R6)
    send_resp(mk_resp(8'd8, 64'h55));
    repeat (2) @(negedge clk);
    for (int j = 0; j < 3; j++) m[j] = mk_req(64'h0000_0ABC_0000_0140 + 64'(j) * 64'h400);
    base = cap_n;
    for (int j = 0; j < 3; j++) send_req(m[j], e1, e2);
    repeat (10) @(negedge clk);
    chk(cap_n - base == 8, "R5 stall at zero credits", 256'(cap_n - base), 256'(8));
    chk(cap_cyc[(base+4)%64] - cap_cyc[(base+3)%64] == 1, "R3 next message back-to-back",
        256'(cap_cyc[(base+4)%64] - cap_cyc[(base+3)%64]), 256'(1));
    chk(!req_ready, "R1 ready low while stalled", 256'(req_ready), 256'(0));
    send_resp(mk_resp(8'd1, 64'h66));
    repeat (6) @(negedge clk);
    chk(cap_n - base == 9, "R6 one credit releases one flit", 256'(cap_n - base), 256'(9));
    send_resp(mk_resp(8'd3, 64'h77));
    repeat (6) @(negedge clk);
    chk(cap_n - base == 12, "R6 remaining flits", 256'(cap_n - base), 256'(12));
    chk_msg_flits(base, m[0], "stall0");
    chk_msg_flits(base + 8, m[2], "stall2");
    chk(req_ready, "R1 ready after tail", 256'(req_ready), 256'(1));

    // saturation: huge return clamps at 8 (R6)
    send_resp(mk_resp(8'd250, 64'h88));
    repeat (2) @(negedge clk);
    base = cap_n;
    for (int j = 0; j < 3; j++) send_req(m[j], e1, e2);
    repeat (10) @(negedge clk);
    chk(cap_n - base == 8, "R6 saturation at CREDITS", 256'(cap_n - base), 256'(8));
    send_resp(mk_resp(8'd4, 64'h99));
    repeat (6) @(negedge clk);
    chk(cap_n - base == 12, "R5 drain after refill", 256'(cap_n - base), 256'(12));

    // response held against stalled mesh (R7, R8)
    resp_ready = 1'b0;
    rm = mk_resp(8'd0, 64'hCAFE_F00D_1234_5678);
    send_resp(rm);
    repeat (5) @(negedge clk);
    chk(resp_valid && resp_msg == rm, "R7 response held", resp_msg, rm);
    chk(!rx_ready, "R8 rx_ready low while full", 256'(rx_ready), 256'(0));
    resp_ready = 1'b1;
    @(negedge clk);
    chk(!resp_valid && rx_ready, "R8 released", 256'({resp_valid, rx_ready}), 256'(2'b01));
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule